// File: doc/BRIEF.md
# MDIO Management Master

This block is the serial management master for PHY devices. It generates the management clock (MDC) from the system clock, drives frames onto the shared management data line (MDIO), and reads back the line when a PHY answers. One host request performs one register read or one register write to one PHY. The request chooses either the short-address framing (Clause 22) or the extended-address framing (Clause 45). For an extended access the block sends an address frame first and then the read or write frame, with no gap between them. The host does nothing between the two frames.

The request side is a valid/ready channel. A request is taken on a rising clock edge at which `req_valid` and `req_ready` are both high. `req_ready` stays low from then until the access completes, and `req_valid` is ignored during that time. The host may hold `req_valid` high for as long as it likes, and the request fields are captured only at the accepting edge. The response is a one-cycle `done` pulse with `rdata` and `ta_err`. It has no back-pressure, so the host must take the response in that cycle.

The MDIO pad is modelled as three signals: `mdio_o`, `mdio_oe` and `mdio_i`. Each MDC half period lasts `MDC_HALF` system clocks. The block changes MDIO only together with a falling MDC edge. It samples MDIO on the rising edge, so setup and hold are each one half period. With a 100 MHz system clock and `MDC_HALF` of at least 2, both exceed 10 ns.

Top module: `mdio_master`

## Requirements
- R1: With no access in progress, `req_ready` is 1, MDC is low and MDIO is released. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the following cycle until the `done` cycle. `req_valid` and the request fields have no effect while `req_ready` is 0.
- R2: Each bit period lasts 2*`MDC_HALF` clock cycles: MDC is low for the first `MDC_HALF` cycles and high for the rest. The first bit period starts in the cycle after acceptance, and frames follow one another without idle cycles.
- R3: `mdio_o` and `mdio_oe` change only in cycles where MDC is low. The master samples `mdio_i` at the clock edge on which MDC rises.
- R4: Every frame starts with 32 bit periods in which the master drives 1. All fields are sent most significant bit first.
- R5: A short-address frame is sent as start bits 0,1, then the opcode (1,0 for read, 0,1 for write), then the 5-bit PHY address, then `req_addr[4:0]`.
- R6: A write frame (either framing) continues with driven bits 1,0 and then the 16 bits of `req_wdata`. MDIO is released when the frame ends.
- R7: A read frame releases MDIO for its last 18 bit periods. The 16 bits sampled in the last 16 bit periods are returned on `rdata`, first sampled bit at bit 15.
- R8: On a read, `ta_err` in the `done` cycle is 1 exactly when the second of the two released turnaround bits was sampled as 1. On a write, `ta_err` is 0.
- R9: An extended-address access is sent as two frames. The address frame is: start 0,0, opcode 0,0, PHY address, device address `req_addr[20:16]`, driven 1,0, then `req_addr[15:0]`, then one released bit period. The data frame follows at once: start 0,0, opcode 1,1 (read) or 0,1 (write), PHY address, the same device address, then the R6 or R7 tail.
- R10: `done` is high for exactly one cycle, in the cycle after the last falling MDC edge of the final frame, and `req_ready` is 1 in that same cycle. `rdata` is valid in that cycle, and it is 0 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_c45 | input | 1 | 1 = extended-address framing, 0 = short-address framing |
| req_phy | input | 5 | PHY address |
| req_addr | input | 21 | Short: register in [4:0]; extended: device [20:16], register [15:0] |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with done |
| ta_err | output | 1 | Turnaround bit from PHY was not 0, valid with done |
| mdc | output | 1 | Management clock, idles low |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The bench applies short-address reads and writes, extended-address reads and writes, and reads in which the PHY drives a 1 in the turnaround slot. The short-against-extended pairs distinguish the start bits, the opcodes and the choice of address field. Reads and writes separate the released tail from the driven tail and show the zeroed `rdata` on writes. Turnaround faults separate `ta_err` from the read data, which is still returned. Further runs issue a request in the `done` cycle, which checks that accesses run back to back. They also toggle `req_valid` and change the fields during a busy period, which shows that the captured request cannot be disturbed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PHY_W   = 5;
  localparam int FLD_W   = 5;
  localparam int DATA_W  = 16;
  localparam int XADDR_W = 21;

  // bits after the preamble: start, opcode, phy, field, turnaround, payload, tail slot
  function automatic int frame_width(input int pre_len);
    return pre_len + 2 + 2 + PHY_W + FLD_W + 2 + DATA_W + 1;
  endfunction

  typedef enum logic [1:0] {
    FK_ADDR  = 2'd0,
    FK_READ  = 2'd1,
    FK_WRITE = 2'd2
  } frame_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_DATA = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic               write;
    logic               c45;
    logic [PHY_W-1:0]   phy;
    logic [XADDR_W-1:0] addr;
    logic [DATA_W-1:0]  wdata;
  } mgmt_req_t;

endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
  parameter int MDC_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);

  localparam int CNT_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MDC_HALF - 1);

  logic [CNT_W-1:0] pcnt;
  logic             wrap;

  assign wrap = run && (pcnt == LAST);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
      mdc  <= 1'b0;
    end else if (start || !run) begin
      pcnt <= '0;
      mdc  <= 1'b0;
    end else if (wrap) begin
      pcnt <= '0;
      mdc  <= ~mdc;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  // R2
  mdc_rise_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $past(run));

  // R2
  mdc_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run) |-> !mdc);

endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int FRAME_W = frame_width(PRE_LEN),
  parameter int NB_W    = $clog2(FRAME_W + 1)
) (
  input  frame_kind_e        kind,
  input  logic               c45,
  input  logic [PHY_W-1:0]   phy,
  input  logic [XADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FRAME_W-1:0] tx_bits,
  output logic [FRAME_W-1:0] oe_bits,
  output logic [NB_W-1:0]    nbits
);

  localparam int HEAD_W = PRE_LEN + 2 + 2 + PHY_W + FLD_W;
  localparam int TAIL_W = FRAME_W - HEAD_W;

  logic [1:0]        start_code;
  logic [1:0]        op_code;
  logic [FLD_W-1:0]  field;
  logic [DATA_W-1:0] payload;
  logic [TAIL_W-1:0] tail_oe;

  always_comb begin
    start_code = c45 ? 2'b00 : 2'b01;
    field      = c45 ? addr[XADDR_W-1:DATA_W] : addr[FLD_W-1:0];
    case (kind)
      FK_ADDR: begin
        op_code = 2'b00;
        payload = addr[DATA_W-1:0];
        tail_oe = {{(TAIL_W-1){1'b1}}, 1'b0};
      end
      FK_WRITE: begin
        op_code = 2'b01;
        payload = wdata;
        tail_oe = {{(TAIL_W-1){1'b1}}, 1'b0};
      end
      default: begin
        op_code = c45 ? 2'b11 : 2'b10;
        payload = '1;
        tail_oe = '0;
      end
    endcase
    tx_bits = {{PRE_LEN{1'b1}}, start_code, op_code, phy, field, 2'b10, payload, 1'b1};
    oe_bits = {{HEAD_W{1'b1}}, tail_oe};
    nbits   = (kind == FK_ADDR) ? NB_W'(FRAME_W) : NB_W'(FRAME_W - 1);
  end

endmodule

// File: rtl/mdio_shift_engine.sv
module mdio_shift_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int FRAME_W = frame_width(PRE_LEN),
  parameter int NB_W    = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] tx_in,
  input  logic [FRAME_W-1:0] oe_in,
  input  logic [NB_W-1:0]    nbits_in,
  input  logic               rise,
  input  logic               fall,
  input  logic               mdio_i,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic               frame_end,
  output logic [DATA_W-1:0]  rx_data,
  output logic               ta_seen
);

  // index of the second turnaround bit, the one the PHY drives
  localparam int TA_IDX = PRE_LEN + 2 + 2 + PHY_W + FLD_W + 1;

  logic [FRAME_W-1:0] tx_sh;
  logic [FRAME_W-1:0] oe_sh;
  logic [NB_W-1:0]    bidx;
  logic [NB_W-1:0]    nb_q;
  logic               last_bit;

  assign last_bit  = (bidx == nb_q - NB_W'(1));
  assign frame_end = fall && last_bit;
  assign mdio_o    = tx_sh[FRAME_W-1];
  assign mdio_oe   = oe_sh[FRAME_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_sh   <= '1;
      oe_sh   <= '0;
      bidx    <= '0;
      nb_q    <= NB_W'(FRAME_W);
      rx_data <= '0;
      ta_seen <= 1'b0;
    end else begin
      if (load) begin
        tx_sh   <= tx_in;
        oe_sh   <= oe_in;
        bidx    <= '0;
        nb_q    <= nbits_in;
        ta_seen <= 1'b0;
      end else if (fall) begin
        if (last_bit) begin
          tx_sh <= '1;
          oe_sh <= '0;
        end else begin
          tx_sh <= {tx_sh[FRAME_W-2:0], 1'b1};
          oe_sh <= {oe_sh[FRAME_W-2:0], 1'b0};
          bidx  <= bidx + 1'b1;
        end
      end
      if (rise) begin
        rx_data <= {rx_data[DATA_W-2:0], mdio_i};
        if (bidx == NB_W'(TA_IDX)) ta_seen <= mdio_i;
      end
    end
  end

  // R6
  frame_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (!mdio_oe || $past(load)));

  // R3
  sample_not_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> !load);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int MDC_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic               req_c45,
  input  logic [PHY_W-1:0]   req_phy,
  input  logic [XADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               done,
  output logic [DATA_W-1:0]  rdata,
  output logic               ta_err,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  input  logic               mdio_i
);

  localparam int FRAME_W = frame_width(PRE_LEN);
  localparam int NB_W    = $clog2(FRAME_W + 1);

  seq_state_e         st_q;
  mgmt_req_t          req_q;
  mgmt_req_t          req_in;
  mgmt_req_t          bld_req;
  frame_kind_e        bld_kind;
  logic               accept;
  logic               load;
  logic               run;
  logic               rise;
  logic               fall;
  logic               frame_end;
  logic [FRAME_W-1:0] tx_bits;
  logic [FRAME_W-1:0] oe_bits;
  logic [NB_W-1:0]    nbits;
  logic [DATA_W-1:0]  rx_data;
  logic               ta_seen;
  logic               done_q;
  logic [DATA_W-1:0]  rdata_q;
  logic               ta_err_q;

  assign req_in = '{write: req_write, c45: req_c45, phy: req_phy,
                    addr: req_addr, wdata: req_wdata};

  assign req_ready = (st_q == SQ_IDLE);
  assign accept    = req_ready && req_valid;
  assign load      = accept || ((st_q == SQ_ADDR) && frame_end);
  assign run       = (st_q != SQ_IDLE);
  assign done      = done_q;
  assign rdata     = rdata_q;
  assign ta_err    = ta_err_q;

  // idle: the frame is built from the live request; busy: only the data frame of the captured one
  always_comb begin
    if (st_q == SQ_IDLE) begin
      bld_req  = req_in;
      bld_kind = req_in.c45 ? FK_ADDR : (req_in.write ? FK_WRITE : FK_READ);
    end else begin
      bld_req  = req_q;
      bld_kind = req_q.write ? FK_WRITE : FK_READ;
    end
  end

  mdio_frame_build #(
    .PRE_LEN (PRE_LEN),
    .FRAME_W (FRAME_W),
    .NB_W    (NB_W)
  ) u_build (
    .kind    (bld_kind),
    .c45     (bld_req.c45),
    .phy     (bld_req.phy),
    .addr    (bld_req.addr),
    .wdata   (bld_req.wdata),
    .tx_bits (tx_bits),
    .oe_bits (oe_bits),
    .nbits   (nbits)
  );

  mdio_bit_timer #(
    .MDC_HALF (MDC_HALF)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (load),
    .run   (run),
    .mdc   (mdc),
    .rise  (rise),
    .fall  (fall)
  );

  mdio_shift_engine #(
    .PRE_LEN (PRE_LEN),
    .FRAME_W (FRAME_W),
    .NB_W    (NB_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .tx_in     (tx_bits),
    .oe_in     (oe_bits),
    .nbits_in  (nbits),
    .rise      (rise),
    .fall      (fall),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .frame_end (frame_end),
    .rx_data   (rx_data),
    .ta_seen   (ta_seen)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SQ_IDLE;
      req_q    <= '0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
      ta_err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SQ_IDLE: begin
          if (req_valid) begin
            req_q <= req_in;
            st_q  <= req_in.c45 ? SQ_ADDR : SQ_DATA;
          end
        end
        SQ_ADDR: begin
          if (frame_end) st_q <= SQ_DATA;
        end
        SQ_DATA: begin
          if (frame_end) begin
            st_q     <= SQ_IDLE;
            done_q   <= 1'b1;
            rdata_q  <= req_q.write ? '0 : rx_data;
            ta_err_q <= !req_q.write && ta_seen;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mdio_oe && !mdc));

  // R1
  busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_ready) |-> $past(req_valid));

  // R3
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

  localparam int H = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_c45 = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, done, ta_err, mdc, mdio_o, mdio_oe, mdio_i;
  logic [15:0] rdata;
  logic        phy_en = 1'b0;
  logic        phy_val = 1'b0;

  always #5 clk = ~clk;

  // pad: PHY drive wins, else master drive, else pull-up
  assign mdio_i = phy_en ? phy_val : (mdio_oe ? mdio_o : 1'b1);

  mdio_master #(.MDC_HALF(H), .PRE_LEN(32)) u_mdio_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_c45(req_c45), .req_phy(req_phy),
    .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .ta_err(ta_err), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  typedef struct {
    bit          mdc, oe, o, done, rdy, pen, pv, te;
    logic [15:0] rd;
    string       tag;
    string       rdtag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   cyc = 0;
  bit   cur_ready = 1'b1;

  task automatic chk(string tag, string what, logic [15:0] got, logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic step();
    exp_t e;
    @(negedge clk);
    if (q.size() > 0) e = q.pop_front();
    else begin
      e = '{mdc: 0, oe: 0, o: 1, done: 0, rdy: 1, pen: 0, pv: 0, te: 0,
            rd: 16'h0, tag: "R1", rdtag: "R1"};
    end
    chk("R2", "mdc", 16'(mdc), 16'(e.mdc));
    chk("R1", "req_ready", 16'(req_ready), 16'(e.rdy));
    chk("R10", "done", 16'(done), 16'(e.done));
    chk(e.tag, "mdio_oe", 16'(mdio_oe), 16'(e.oe));
    if (e.oe) chk({e.tag, "/R3"}, "mdio_o", 16'(mdio_o), 16'(e.o));
    if (e.done) begin
      chk(e.rdtag, "rdata", rdata, e.rd);
      chk("R8", "ta_err", 16'(ta_err), 16'(e.te));
    end
    cur_ready = e.rdy;
    phy_en    = e.pen;
    phy_val   = e.pv;
  endtask

  task automatic push_bit(bit v, bit oe, bit pen, bit pv, string tag);
    for (int k = 0; k < 2*H; k++) begin
      exp_t e;
      e = '{mdc: (k >= H), oe: oe, o: v, done: 0, rdy: 0, pen: pen, pv: pv,
            te: 0, rd: 16'h0, tag: tag, rdtag: ""};
      q.push_back(e);
    end
  endtask

  task automatic push_drv(logic [20:0] v, int w, string tag);
    for (int i = w - 1; i >= 0; i--) push_bit(v[i], 1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic push_preamble();
    // R4: 32 driven ones
    for (int i = 0; i < 32; i++) push_bit(1'b1, 1'b1, 1'b0, 1'b0, "R4");
  endtask

  task automatic model_req(bit wr, bit c45, logic [4:0] phy, logic [20:0] addr,
                           logic [15:0] wd, logic [15:0] pdata, bit ta_bad);
    string ft;
    exp_t  e;
    ft = c45 ? "R9" : "R5";
    if (c45) begin
      push_preamble();
      push_drv(21'd0, 2, "R9");
      push_drv(21'd0, 2, "R9");
      push_drv(21'(phy), 5, "R9");
      push_drv(21'(addr[20:16]), 5, "R9");
      push_drv(21'd2, 2, "R9");
      push_drv(21'(addr[15:0]), 16, "R9");
      push_bit(1'b1, 1'b0, 1'b0, 1'b0, "R9");
    end
    push_preamble();
    push_drv(c45 ? 21'd0 : 21'd1, 2, ft);
    push_drv(c45 ? (wr ? 21'd1 : 21'd3) : (wr ? 21'd1 : 21'd2), 2, ft);
    push_drv(21'(phy), 5, ft);
    push_drv(c45 ? 21'(addr[20:16]) : 21'(addr[4:0]), 5, ft);
    if (wr) begin
      push_drv(21'd2, 2, "R6");
      push_drv(21'(wd), 16, "R6");
    end else begin
      push_bit(1'b1, 1'b0, 1'b0, 1'b0, "R7");
      push_bit(1'b1, 1'b0, 1'b1, ta_bad, "R8");
      for (int i = 15; i >= 0; i--) push_bit(1'b1, 1'b0, 1'b1, pdata[i], "R7");
    end
    e = '{mdc: 0, oe: 0, o: 1, done: 1, rdy: 1, pen: 0, pv: 0,
          te: (!wr && ta_bad), rd: (wr ? 16'h0 : pdata), tag: "R10",
          rdtag: (wr ? "R10" : "R7")};
    q.push_back(e);
  endtask

  task automatic issue(bit wr, bit c45, logic [4:0] phy, logic [20:0] addr,
                       logic [15:0] wd, logic [15:0] pdata, bit ta_bad);
    req_write = wr; req_c45 = c45; req_phy = phy; req_addr = addr; req_wdata = wd;
    req_valid = 1'b1;
    while (!cur_ready) step();
    model_req(wr, c45, phy, addr, wd, pdata, ta_bad);
    step();
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() > 0) step();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 R2: reset state, idle and quiet
    repeat (4) step();

    // R5 R7: short-address read
    issue(1'b0, 1'b0, 5'h11, 21'h0000A, 16'h0, 16'hA53C, 1'b0);
    drain();
    // R5 R6: short-address write, then R1 fields/valid changed while busy
    issue(1'b1, 1'b0, 5'h03, 21'h0001F, 16'h8001, 16'h0, 1'b0);
    req_write = 1'b0; req_c45 = 1'b1; req_phy = 5'h1F; req_addr = 21'h1FFFFF;
    req_valid = 1'b1;
    repeat (12) step();
    req_valid = 1'b0;
    repeat (5) step();
    req_valid = 1'b1;
    repeat (3) step();
    req_valid = 1'b0;
    drain();
    // R8: short-address read with turnaround fault
    issue(1'b0, 1'b0, 5'h00, 21'h00001, 16'h0, 16'hFFFF, 1'b1);
    drain();
    // R9: extended read, back to back with the done cycle (R10)
    issue(1'b0, 1'b1, 5'h1E, 21'h1BC0DE, 16'h0, 16'h0001, 1'b0);
    drain();
    issue(1'b1, 1'b1, 5'h00, 21'h00FFFF, 16'h5AA5, 16'h0, 1'b0);
    drain();
    // R8 R9: extended read with turnaround fault
    issue(1'b0, 1'b1, 5'h15, 21'h0A8000, 16'h0, 16'h1234, 1'b1);
    drain();
    // R5: read of register 0 returning zeros
    issue(1'b0, 1'b0, 5'h1F, 21'h1FFE0, 16'h0, 16'h0000, 1'b0);
    drain();
    repeat (6) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule